// File: doc/BRIEF.md
# Registered Two-Port Bus Transceiver

This block joins two parallel buses, called side A and side B, and carries data across in one direction at a time. Each direction has its own capture register. The A-side register samples bus A on the rising edge of the A-to-B clock. The B-side register samples bus B on the rising edge of the B-to-A clock. Whichever bus is being driven can carry one of two values: the live value on the opposite bus, or the copy held in the register for that direction.

The data path is split into independent lanes, with two 8-bit lanes by default. Each lane has its own set of controls:

- an active-low output enable;
- a direction select;
- an A-to-B clock and a B-to-A clock;
- an A-to-B live/held select and a B-to-A live/held select.

The bus pins are modelled as separate input, output and output-enable vectors, so the block contains no tri-state logic. A pad ring or a surrounding bus fabric resolves the enables into real bidirectional nets.

Capture never depends on the output controls. A lane whose outputs are isolated can still store data from either side and forward it once its outputs are enabled.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On a rising edge of `clk_ab[i]` with `rst_n` high, the A-side register of lane i takes the value on `a_in` bits [i*LANE_W +: LANE_W].
- R2: On a rising edge of `clk_ba[i]` with `rst_n` high, the B-side register of lane i takes the value on `b_in` bits of lane i.
- R3: Capture takes place whatever the values of `oe_n[i]` and `dir[i]`, and this includes isolation. Data captured during isolation is forwarded once the outputs are enabled.
- R4: While `oe_n[i]` is 1, every bit of lane i in `a_oe` and `b_oe` is 0, and the lane's bits of `a_out` and `b_out` read 0.
- R5: While `oe_n[i]` is 0, `dir[i]`=1 sets every lane-i bit of `b_oe` to 1 and every lane-i bit of `a_oe` to 0. `dir[i]`=0 does the opposite. A lane never drives both buses at once.
- R6: While lane i drives B, `sel_ab[i]`=0 puts the live lane-i value of `a_in` on `b_out`, and `sel_ab[i]`=1 puts the A-side register on `b_out`.
- R7: While lane i drives A, `sel_ba[i]`=0 puts the live lane-i value of `b_in` on `a_out`, and `sel_ba[i]`=1 puts the B-side register on `a_out`.
- R8: Controls, clocks and registers of one lane have no effect on the bits or the stored data of any other lane.
- R9: A rising edge of a lane clock while `rst_n` is 0 clears the register it clocks to zero.
- R10: A change of a select, the direction or a live bus input appears on the outputs in the same cycle, with no register stage in the way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Synchronous active-low clear of the capture registers |
| clk_ab | input | N_LANES | Per-lane A-side capture clock |
| clk_ba | input | N_LANES | Per-lane B-side capture clock |
| oe_n | input | N_LANES | Per-lane output enable, active low |
| dir | input | N_LANES | Per-lane direction: 1 drives B, 0 drives A |
| sel_ab | input | N_LANES | Per-lane B-output select: 0 live A, 1 held A |
| sel_ba | input | N_LANES | Per-lane A-output select: 0 live B, 1 held B |
| a_in | input | N_LANES*LANE_W | Value sensed on bus A |
| a_out | output | N_LANES*LANE_W | Value to drive onto bus A |
| a_oe | output | N_LANES*LANE_W | Bitwise drive enable for bus A |
| b_in | input | N_LANES*LANE_W | Value sensed on bus B |
| b_out | output | N_LANES*LANE_W | Value to drive onto bus B |
| b_oe | output | N_LANES*LANE_W | Bitwise drive enable for bus B |

## Verification
The assertions check several rules on every edge of a lane clock:

- an isolated lane drives nothing;
- a lane never enables both buses;
- the live paths mirror the opposite bus;
- a held path shows the value that bus carried at the previous edge of its clock.

Some behaviour only the bench's scenarios can show. These are that data latched during isolation later reaches the far bus, that activity in one lane leaves the other lane's held data untouched, and that a select flip between clock edges changes the output at once.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   typedef enum logic {
      DRIVE_A = 1'b0,
      DRIVE_B = 1'b1
   } xdir_e;

   typedef struct packed {
      logic  oe_n;
      xdir_e dir;
      logic  sel_ab;
      logic  sel_ba;
   } lane_ctrl_t;

endpackage

// File: rtl/xcvr_hold_reg.sv
module xcvr_hold_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   initial begin
      assert (W >= 1) else $error("xcvr_hold_reg: W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end

endmodule

// File: rtl/xcvr_route.sv
module xcvr_route
   import xcvr_pkg::*;
#(
   parameter int W         = 8,
   parameter bit PARK_ZERO = 1'b1
) (
   input  lane_ctrl_t   ctrl,
   input  logic [W-1:0] a_live,
   input  logic [W-1:0] b_live,
   input  logic [W-1:0] a_held,
   input  logic [W-1:0] b_held,
   output logic [W-1:0] a_out,
   output logic [W-1:0] a_oe,
   output logic [W-1:0] b_out,
   output logic [W-1:0] b_oe
);

   logic         drv_a, drv_b;
   logic [W-1:0] to_a, to_b;

   always_comb begin
      drv_a = !ctrl.oe_n && (ctrl.dir == DRIVE_A);
      drv_b = !ctrl.oe_n && (ctrl.dir == DRIVE_B);
      to_b  = ctrl.sel_ab ? a_held : a_live;
      to_a  = ctrl.sel_ba ? b_held : b_live;
   end

   assign a_oe = {W{drv_a}};
   assign b_oe = {W{drv_b}};

   generate
      if (PARK_ZERO) begin : g_park
         assign a_out = drv_a ? to_a : '0;
         assign b_out = drv_b ? to_b : '0;
      end else begin : g_pass
         assign a_out = to_a;
         assign b_out = to_b;
      end
   endgenerate

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
   import xcvr_pkg::*;
#(
   parameter int W         = 8,
   parameter bit PARK_ZERO = 1'b1
) (
   input  logic         rst_n,
   input  logic         clk_ab,
   input  logic         clk_ba,
   input  lane_ctrl_t   ctrl,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   output logic [W-1:0] a_out,
   output logic [W-1:0] a_oe,
   output logic [W-1:0] b_out,
   output logic [W-1:0] b_oe
);

   logic [W-1:0] held_a, held_b;

   xcvr_hold_reg #(.W(W)) u_hold_a (
      .clk   (clk_ab),
      .rst_n (rst_n),
      .d     (a_in),
      .q     (held_a)
   );

   xcvr_hold_reg #(.W(W)) u_hold_b (
      .clk   (clk_ba),
      .rst_n (rst_n),
      .d     (b_in),
      .q     (held_b)
   );

   xcvr_route #(.W(W), .PARK_ZERO(PARK_ZERO)) u_route (
      .ctrl   (ctrl),
      .a_live (a_in),
      .b_live (b_in),
      .a_held (held_a),
      .b_held (held_b),
      .a_out  (a_out),
      .a_oe   (a_oe),
      .b_out  (b_out),
      .b_oe   (b_oe)
   );

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
   import xcvr_pkg::*;
#(
   parameter int LANE_W    = 8,
   parameter int N_LANES   = 2,
   parameter bit PARK_ZERO = 1'b1,
   localparam int BUS_W    = LANE_W * N_LANES
) (
   input  logic               rst_n,
   input  logic [N_LANES-1:0] clk_ab,
   input  logic [N_LANES-1:0] clk_ba,
   input  logic [N_LANES-1:0] oe_n,
   input  logic [N_LANES-1:0] dir,
   input  logic [N_LANES-1:0] sel_ab,
   input  logic [N_LANES-1:0] sel_ba,
   input  logic [BUS_W-1:0]   a_in,
   output logic [BUS_W-1:0]   a_out,
   output logic [BUS_W-1:0]   a_oe,
   input  logic [BUS_W-1:0]   b_in,
   output logic [BUS_W-1:0]   b_out,
   output logic [BUS_W-1:0]   b_oe
);

   initial begin
      assert (LANE_W >= 1)  else $error("bus_xcvr_reg: LANE_W must be at least 1");
      assert (N_LANES >= 1) else $error("bus_xcvr_reg: N_LANES must be at least 1");
   end

   generate
      for (genvar i = 0; i < N_LANES; i++) begin : g_lane
         lane_ctrl_t ctrl;

         always_comb begin
            ctrl.oe_n   = oe_n[i];
            ctrl.dir    = xdir_e'(dir[i]);
            ctrl.sel_ab = sel_ab[i];
            ctrl.sel_ba = sel_ba[i];
         end

         xcvr_lane #(.W(LANE_W), .PARK_ZERO(PARK_ZERO)) u_lane (
            .rst_n  (rst_n),
            .clk_ab (clk_ab[i]),
            .clk_ba (clk_ba[i]),
            .ctrl   (ctrl),
            .a_in   (a_in [i*LANE_W +: LANE_W]),
            .b_in   (b_in [i*LANE_W +: LANE_W]),
            .a_out  (a_out[i*LANE_W +: LANE_W]),
            .a_oe   (a_oe [i*LANE_W +: LANE_W]),
            .b_out  (b_out[i*LANE_W +: LANE_W]),
            .b_oe   (b_oe [i*LANE_W +: LANE_W])
         );
      end
   endgenerate

endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
   parameter int LANE_W  = 8,
   parameter int N_LANES = 2,
   localparam int BUS_W  = LANE_W * N_LANES
) (
   input logic               rst_n,
   input logic [N_LANES-1:0] clk_ab,
   input logic [N_LANES-1:0] clk_ba,
   input logic [N_LANES-1:0] oe_n,
   input logic [N_LANES-1:0] dir,
   input logic [N_LANES-1:0] sel_ab,
   input logic [N_LANES-1:0] sel_ba,
   input logic [BUS_W-1:0]   a_in,
   input logic [BUS_W-1:0]   a_out,
   input logic [BUS_W-1:0]   a_oe,
   input logic [BUS_W-1:0]   b_in,
   input logic [BUS_W-1:0]   b_out,
   input logic [BUS_W-1:0]   b_oe
);

   generate
      for (genvar g = 0; g < N_LANES; g++) begin : g_chk
         // R4
         iso_quiet_chk: assert property (@(posedge clk_ab[g]) disable iff (!rst_n)
            oe_n[g] |-> (a_oe[g*LANE_W +: LANE_W] == '0) && (b_oe[g*LANE_W +: LANE_W] == '0));

         // R5
         one_side_chk: assert property (@(posedge clk_ab[g]) disable iff (!rst_n)
            !((|a_oe[g*LANE_W +: LANE_W]) && (|b_oe[g*LANE_W +: LANE_W])));

         // R6
         live_ab_chk: assert property (@(posedge clk_ab[g]) disable iff (!rst_n)
            (!oe_n[g] && dir[g] && !sel_ab[g]) |->
               b_out[g*LANE_W +: LANE_W] == a_in[g*LANE_W +: LANE_W]);

         // R1
         held_ab_chk: assert property (@(posedge clk_ab[g]) disable iff (!rst_n)
            ($past(rst_n) && !oe_n[g] && dir[g] && sel_ab[g]) |->
               b_out[g*LANE_W +: LANE_W] == $past(a_in[g*LANE_W +: LANE_W]));

         // R7
         live_ba_chk: assert property (@(posedge clk_ba[g]) disable iff (!rst_n)
            (!oe_n[g] && !dir[g] && !sel_ba[g]) |->
               a_out[g*LANE_W +: LANE_W] == b_in[g*LANE_W +: LANE_W]);

         // R2
         held_ba_chk: assert property (@(posedge clk_ba[g]) disable iff (!rst_n)
            ($past(rst_n) && !oe_n[g] && !dir[g] && sel_ba[g]) |->
               a_out[g*LANE_W +: LANE_W] == $past(b_in[g*LANE_W +: LANE_W]));
      end
   endgenerate

endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.LANE_W(LANE_W), .N_LANES(N_LANES)) u_chk (
   .rst_n  (rst_n),
   .clk_ab (clk_ab),
   .clk_ba (clk_ba),
   .oe_n   (oe_n),
   .dir    (dir),
   .sel_ab (sel_ab),
   .sel_ba (sel_ba),
   .a_in   (a_in),
   .a_out  (a_out),
   .a_oe   (a_oe),
   .b_in   (b_in),
   .b_out  (b_out),
   .b_oe   (b_oe)
);

// File: tb/sim_bus_xcvr_reg.sv
module sim_bus_xcvr_reg;

   localparam int CLK_T = 10;
   localparam int LW    = 8;
   localparam int NL    = 2;
   localparam int BW    = LW * NL;

   logic          rst_n;
   logic [NL-1:0] clk_ab, clk_ba, oe_n, dir, sel_ab, sel_ba;
   logic [BW-1:0] a_in, b_in, a_out, a_oe, b_out, b_oe;

   bus_xcvr_reg #(.LANE_W(LW), .N_LANES(NL)) u0 (
      .rst_n  (rst_n),
      .clk_ab (clk_ab),
      .clk_ba (clk_ba),
      .oe_n   (oe_n),
      .dir    (dir),
      .sel_ab (sel_ab),
      .sel_ba (sel_ba),
      .a_in   (a_in),
      .a_out  (a_out),
      .a_oe   (a_oe),
      .b_in   (b_in),
      .b_out  (b_out),
      .b_oe   (b_oe)
   );

   typedef struct {
      logic [BW-1:0] ao, aoe, bo, boe;
      string         rq;
   } item_t;

   item_t       q[$];
   logic [LW-1:0] m_a [NL];
   logic [LW-1:0] m_b [NL];
   int  total = 0;
   int  bad   = 0;
   bit  done  = 0;

   // Bench model of the capture registers
   task automatic pulse(input bit ab, input int ln);
      #(CLK_T/2);
      if (ab) begin
         clk_ab[ln] = 1'b1;
         m_a[ln] = rst_n ? a_in[ln*LW +: LW] : '0;
      end else begin
         clk_ba[ln] = 1'b1;
         m_b[ln] = rst_n ? b_in[ln*LW +: LW] : '0;
      end
      #(CLK_T/2);
      clk_ab[ln] = 1'b0;
      clk_ba[ln] = 1'b0;
   endtask

   // Driver: predict outputs from the model, push to scoreboard
   task automatic expect_now(input string rq);
      item_t it;
      #1;
      it.ao = '0; it.aoe = '0; it.bo = '0; it.boe = '0; it.rq = rq;
      for (int l = 0; l < NL; l++) begin
         if (!oe_n[l] && dir[l]) begin
            it.boe[l*LW +: LW] = '1;
            it.bo[l*LW +: LW]  = sel_ab[l] ? m_a[l] : a_in[l*LW +: LW];
         end else if (!oe_n[l] && !dir[l]) begin
            it.aoe[l*LW +: LW] = '1;
            it.ao[l*LW +: LW]  = sel_ba[l] ? m_b[l] : b_in[l*LW +: LW];
         end
      end
      q.push_back(it);
      #1;
   endtask

   // Monitor
   initial begin
      forever begin
         item_t it;
         wait (q.size() != 0);
         it = q.pop_front();
         total++;
         if (a_out !== it.ao || a_oe !== it.aoe || b_out !== it.bo || b_oe !== it.boe) begin
            bad++;
            $display("FAIL %s: got a_out=%h a_oe=%h b_out=%h b_oe=%h exp a_out=%h a_oe=%h b_out=%h b_oe=%h",
                     it.rq, a_out, a_oe, b_out, b_oe, it.ao, it.aoe, it.bo, it.boe);
         end
      end
   end

   initial begin
      #(CLK_T * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 0; clk_ab = '0; clk_ba = '0;
      oe_n = '1; dir = '0; sel_ab = '0; sel_ba = '0;
      a_in = 16'hA5C3; b_in = 16'h3C7E;
      for (int l = 0; l < NL; l++) begin
         m_a[l] = 'x;
         m_b[l] = 'x;
      end

      // R9: clear under reset, R4: isolated lanes quiet
      for (int l = 0; l < NL; l++) begin
         pulse(1, l);
         pulse(0, l);
      end
      rst_n = 1;
      expect_now("R4");
      oe_n = 2'b00; dir = 2'b01; sel_ab = 2'b01; sel_ba = 2'b10;
      expect_now("R9");

      // R6: live A to B on lane 0 with several patterns, R10 combinational
      sel_ab = 2'b00;
      a_in = 16'h0000; expect_now("R6");
      a_in = 16'h00FF; expect_now("R6");
      a_in = 16'h1281; expect_now("R10");

      // R1: capture, then change live value and select held copy
      a_in = 16'h775A;
      pulse(1, 0);
      a_in = 16'h7733;
      sel_ab = 2'b01; expect_now("R1");
      sel_ab = 2'b00; expect_now("R10");

      // R2, R7: lane 1 drives A
      b_in = 16'hC300; pulse(0, 1);
      b_in = 16'h1100;
      sel_ba = 2'b00; expect_now("R7");
      sel_ba = 2'b10; expect_now("R2");

      // R3: capture while isolated, then forward
      oe_n = 2'b11;
      a_in = 16'h9E00; b_in = 16'h0071;
      pulse(1, 1);
      pulse(0, 0);
      expect_now("R4");
      a_in = 16'h0000; b_in = 16'h0000;
      oe_n = 2'b00; dir = 2'b10; sel_ab = 2'b10; sel_ba = 2'b01;
      expect_now("R3");

      // R8: lane 0 clock activity leaves lane 1 held data alone
      a_in = 16'hEE44; pulse(1, 0);
      b_in = 16'hDD22; pulse(0, 0);
      expect_now("R8");
      sel_ba = 2'b00; expect_now("R8");

      // R5: direction flips
      dir = 2'b01; expect_now("R5");
      dir = 2'b00; expect_now("R5");
      dir = 2'b11; sel_ab = 2'b11; expect_now("R5");

      // R9: reset clears only the register clocked
      rst_n = 0; pulse(1, 0); rst_n = 1;
      expect_now("R9");

      #(CLK_T);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule